// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block turns a set of pending interrupt levels into one registered hardware interrupt request and a trap-type index. It merges two sources into one pending vector:

- a vector of level lines driven from outside;
- a software interrupt register that also carries two timer-match flags.

The resolver picks the highest pending level that lies strictly above the processor's current interrupt level. It encodes that level into the external-interrupt trap-type group, and raises the request only when the result differs from the index it already holds.

Three conditions keep or drop the request.

- A pending vector interrupt has precedence. While the vector-busy flag is set, the resolver freezes its outputs.
- When interrupts are globally disabled, an active request is withdrawn.
- When the processor is already handling an external-interrupt trap of higher type at a nonzero trap level, a new lower level cannot preempt it. The held request then stays as it was.

Outputs change on the rising clock edge that samples the inputs. Trap entry is left to the consumer of the request.

Top module: `irq_level_resolver`

## Requirements
- R1: During and after synchronous reset, `irq_req` is 0 and `irq_tt` is 0.
- R2: The pending set is the OR of `lvl_in` and `soft_int` bits 1 to NLVL-1. A set bit at position n in either source stands for level n.
- R3: `soft_int` bit 0 (tick match) and bit 16 (system tick match) are not levels themselves. If either of them is set, level 14 is added to the pending set.
- R4: While `vec_busy` is 1 at a clock edge, `irq_req` and `irq_tt` keep their values across that edge, whatever the other inputs are.
- R5: If no pending level is strictly above `cur_lvl`, an active request is withdrawn: `irq_req` goes to 0 and `irq_tt` goes to 0. This covers `cur_lvl` = 15, which masks every level, and a pending level equal to `cur_lvl`.
- R6: When enabled, the highest pending level L above `cur_lvl` gives the trap type 0x40 | L (9 bits, so 0x41 to 0x4F). If that type differs from `irq_tt`, then after the edge `irq_tt` holds it and `irq_req` is 1.
- R7: The new type is suppressed and both outputs are kept when all three hold: `trap_lvl` is nonzero, `cur_tt[8:4]` equals 5'h04, and `cur_tt` is greater than the new type.
- R8: A new type is not suppressed if `trap_lvl` is 0, if `cur_tt[8:4]` is not 5'h04, or if `cur_tt` is less than or equal to the new type.
- R9: With `int_en` = 0 and a pending level above `cur_lvl`, an active request is withdrawn (both outputs go to 0). When no request is active, both outputs stay 0.
- R10: Outputs are registered. Every input change shows at the outputs exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_in | input | 16 | External interrupt level lines, bit n = level n |
| soft_int | input | 17 | Software interrupt register: bit 0 tick match, bits 1..15 levels, bit 16 system tick match |
| cur_lvl | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | Vector interrupt pending; freezes the outputs |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type currently being handled |
| irq_req | output | 1 | Registered hardware interrupt request |
| irq_tt | output | 9 | Registered trap-type index, 0 when no request is active |

## Verification
The bench builds the block with its default parameters:

- 16 levels;
- a 17-bit software register with the timer flags at bits 0 and 16, remapped to level 14;
- a 9-bit trap type with base 0x40;
- a 3-bit trap level.

With these values the whole level range is reachable, up to the masking case `cur_lvl` = 15. The nested-trap comparison can be steered on both sides of the group boundary, for example with 0x147, which lies outside the group. The width of the software register lets both timer flags be exercised separately.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int NLVL_D      = 16;
    localparam int SOFT_W_D    = 17;
    localparam int TT_W_D      = 9;
    localparam int TL_W_D      = 3;
    localparam int TICK_BIT_D  = 0;
    localparam int STICK_BIT_D = 16;
    localparam int TIMER_LVL_D = 14;
    localparam int EXT_BASE_D  = 'h040;
    localparam int GRP_LSB_D   = 4;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_RAISE = 2'd2
    } act_e;

    // Decide what the output register does this cycle.
    function automatic act_e pick_action(
        input logic busy,
        input logic any_above,
        input logic en,
        input logic req_now,
        input logic blocked,
        input logic differs
    );
        act_e a;
        a = ACT_HOLD;
        if (busy)
            a = ACT_HOLD;
        else if (!any_above)
            a = req_now ? ACT_CLEAR : ACT_HOLD;
        else if (en)
            a = (!blocked && differs) ? ACT_RAISE : ACT_HOLD;
        else
            a = req_now ? ACT_CLEAR : ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/ilr_pend_merge.sv
module ilr_pend_merge #(
    parameter int NLVL      = 16,
    parameter int SOFT_W    = 17,
    parameter int TICK_BIT  = 0,
    parameter int STICK_BIT = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [NLVL-1:0]   lvl_in,
    input  logic [SOFT_W-1:0] soft_int,
    output logic [NLVL-1:0]   pend
);
    localparam int SW_USED = (SOFT_W < NLVL) ? SOFT_W : NLVL;

    logic [NLVL-1:0] soft_lvls;
    logic            timer_hit;

    always_comb begin
        soft_lvls = '0;
        for (int i = 0; i < SW_USED; i++) begin
            if (i != TICK_BIT && i != STICK_BIT)
                soft_lvls[i] = soft_int[i];
        end
    end

    assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

    always_comb begin
        pend = lvl_in | soft_lvls;
        if (timer_hit)
            pend[TIMER_LVL] = 1'b1;
    end
endmodule

// File: rtl/ilr_scan.sv
module ilr_scan #(
    parameter int NLVL  = 16,
    parameter int LVL_W = 4
) (
    input  logic [NLVL-1:0]  pend,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             any_above,
    output logic [LVL_W-1:0] win_lvl
);
    logic [NLVL-1:0] above_mask;

    for (genvar g = 0; g < NLVL; g++) begin : g_mask
        assign above_mask[g] = (g > int'(cur_lvl));
    end

    assign any_above = |(pend & above_mask);

    // Ascending scan: the last hit is the highest level.
    always_comb begin
        win_lvl = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (pend[i] && above_mask[i])
                win_lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/ilr_nest_gate.sv
module ilr_nest_gate #(
    parameter int TT_W     = 9,
    parameter int TL_W     = 3,
    parameter int LVL_W    = 4,
    parameter int EXT_BASE = 'h040,
    parameter int GRP_LSB  = 4
) (
    input  logic [LVL_W-1:0] win_lvl,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic [TT_W-1:0]  cur_tt,
    output logic [TT_W-1:0]  win_tt,
    output logic             blocked
);
    localparam logic [TT_W-1:0] BASE = TT_W'(EXT_BASE);

    logic in_group;

    assign win_tt   = BASE | TT_W'(win_lvl);
    assign in_group = (cur_tt[TT_W-1:GRP_LSB] == BASE[TT_W-1:GRP_LSB]);
    assign blocked  = (trap_lvl != '0) && in_group && (cur_tt > win_tt);
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_lvl_pkg::*;
#(
    parameter int NLVL      = NLVL_D,
    parameter int SOFT_W    = SOFT_W_D,
    parameter int TT_W      = TT_W_D,
    parameter int TL_W      = TL_W_D,
    parameter int TICK_BIT  = TICK_BIT_D,
    parameter int STICK_BIT = STICK_BIT_D,
    parameter int TIMER_LVL = TIMER_LVL_D,
    parameter int EXT_BASE  = EXT_BASE_D,
    parameter int GRP_LSB   = GRP_LSB_D
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NLVL-1:0]              lvl_in,
    input  logic [SOFT_W-1:0]            soft_int,
    input  logic [$clog2(NLVL)-1:0]      cur_lvl,
    input  logic                         int_en,
    input  logic                         vec_busy,
    input  logic [TL_W-1:0]              trap_lvl,
    input  logic [TT_W-1:0]              cur_tt,
    output logic                         irq_req,
    output logic [TT_W-1:0]              irq_tt
);
    localparam int LVL_W = $clog2(NLVL);

    logic [NLVL-1:0]  pend;
    logic             any_above;
    logic [LVL_W-1:0] win_lvl;
    logic [TT_W-1:0]  win_tt;
    logic             blocked;
    act_e             act;

    ilr_pend_merge #(
        .NLVL(NLVL), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
        .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
    ) u_merge (
        .lvl_in(lvl_in), .soft_int(soft_int), .pend(pend)
    );

    ilr_scan #(.NLVL(NLVL), .LVL_W(LVL_W)) u_scan (
        .pend(pend), .cur_lvl(cur_lvl),
        .any_above(any_above), .win_lvl(win_lvl)
    );

    ilr_nest_gate #(
        .TT_W(TT_W), .TL_W(TL_W), .LVL_W(LVL_W),
        .EXT_BASE(EXT_BASE), .GRP_LSB(GRP_LSB)
    ) u_gate (
        .win_lvl(win_lvl), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
        .win_tt(win_tt), .blocked(blocked)
    );

    assign act = pick_action(vec_busy, any_above, int_en, irq_req,
                             blocked, win_tt != irq_tt);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req <= 1'b0;
            irq_tt  <= '0;
        end else begin
            case (act)
                ACT_CLEAR: begin
                    irq_req <= 1'b0;
                    irq_tt  <= '0;
                end
                ACT_RAISE: begin
                    irq_req <= 1'b1;
                    irq_tt  <= win_tt;
                end
                default: ;
            endcase
        end
    end

    // R4: a busy vector freezes the outputs
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
        vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

    // R5: no active request means a zero index
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_tt == '0));

    // R6: an active index always lies in the external group, level nonzero
    a_r6_idx_group: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((irq_tt[TT_W-1:GRP_LSB] == EXT_BASE[TT_W-1:GRP_LSB])
                     && (irq_tt[LVL_W-1:0] != '0)));

    // R6: a new index comes from a level above the sampled current level
    a_r6_above_cur: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !$stable(irq_tt)) |-> (irq_tt[LVL_W-1:0] > $past(cur_lvl)));

    // R9: a request only rises while interrupts were enabled
    a_r9_raise_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(int_en));
endmodule

// File: tb/sim_irq_level_resolver.sv
module sim_irq_level_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lvl_in = '0;
    logic [16:0] soft_int = '0;
    logic [3:0]  cur_lvl = '0;
    logic        int_en = 1'b0;
    logic        vec_busy = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  cur_tt = '0;
    logic        irq_req;
    logic [8:0]  irq_tt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic        req;
        logic [8:0]  tt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic       m_req = 1'b0;
    logic [8:0] m_tt  = '0;

    always #2.5 clk = ~clk;

    irq_level_resolver u0 (
        .clk(clk), .rst(rst), .lvl_in(lvl_in), .soft_int(soft_int),
        .cur_lvl(cur_lvl), .int_en(int_en), .vec_busy(vec_busy),
        .trap_lvl(trap_lvl), .cur_tt(cur_tt),
        .irq_req(irq_req), .irq_tt(irq_tt)
    );

    // Reference built from the requirement text.
    task automatic model_step();
        logic [15:0] p;
        int          best;
        logic [8:0]  t;
        p = lvl_in | {soft_int[15:1], 1'b0};
        if (soft_int[0] || soft_int[16]) p[14] = 1'b1;
        best = -1;
        for (int k = 15; k > int'(cur_lvl); k--)
            if (best < 0 && p[k]) best = k;
        if (vec_busy) return;
        if (best < 0) begin
            if (m_req) begin m_req = 1'b0; m_tt = '0; end
        end else if (int_en) begin
            t = 9'h040 | 9'(best);
            if (trap_lvl != 0 && cur_tt[8:4] == 5'h04 && cur_tt > t) ;
            else if (t != m_tt) begin m_req = 1'b1; m_tt = t; end
        end else if (m_req) begin
            m_req = 1'b0; m_tt = '0;
        end
    endtask

    task automatic apply(input logic [15:0] l, input logic [16:0] s,
                         input logic [3:0] c, input logic e, input logic b,
                         input logic [2:0] tl, input logic [8:0] tt,
                         input string tag);
        exp_t x;
        @(negedge clk);
        lvl_in = l; soft_int = s; cur_lvl = c; int_en = e;
        vec_busy = b; trap_lvl = tl; cur_tt = tt;
        model_step();
        @(posedge clk);
        x.req = m_req; x.tt = m_tt; x.tag = tag;
        sb.push_back(x);
    endtask

    // Monitor: compare one expected item per falling edge.
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                x = sb.pop_front();
                n_run++;
                if (irq_req !== x.req || irq_tt !== x.tt) begin
                    n_fail++;
                    $display("FAIL %s: got req=%0b tt=%h, expected req=%0b tt=%h",
                             x.tag, irq_req, irq_tt, x.req, x.tt);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (irq_req !== 1'b0 || irq_tt !== 9'h0) begin
            n_fail++;
            $display("FAIL R1: got req=%0b tt=%h, expected req=0 tt=000", irq_req, irq_tt);
        end
        rst = 1'b0;
        apply(16'h0008, '0, 4'd0, 1, 0, 0, 0, "R6 single level 3");
        apply(16'h0208, '0, 4'd0, 1, 0, 0, 0, "R6 highest of 3,9 (R10)");
        apply(16'h0000, 17'h01000, 4'd0, 1, 0, 0, 0, "R2 soft level 12");
        apply(16'h0000, 17'h00001, 4'd0, 1, 0, 0, 0, "R3 tick to level 14");
        apply(16'h0020, '0, 4'd0, 1, 0, 0, 0, "R6 back to level 5");
        apply(16'h0000, 17'h10000, 4'd0, 1, 0, 0, 0, "R3 stick to level 14");
        apply(16'h0001, '0, 4'd0, 1, 0, 0, 0, "R5 level 0 only clears");
        apply(16'h0020, '0, 4'd0, 1, 1, 0, 0, "R4 busy ignores pending");
        apply(16'h0080, '0, 4'd0, 1, 0, 0, 0, "R6 level 7");
        apply(16'h0000, '0, 4'd0, 0, 1, 0, 0, "R4 busy keeps active");
        apply(16'h0080, '0, 4'd7, 1, 0, 0, 0, "R5 equal to current clears");
        apply(16'h4000, '0, 4'd3, 1, 0, 0, 0, "R6 level 14 over cur 3");
        apply(16'hFFFF, 17'h1FFFF, 4'd15, 1, 0, 0, 0, "R5 cur 15 masks all");
        apply(16'h0008, '0, 4'd0, 1, 0, 0, 0, "R6 level 3 again");
        apply(16'h0028, '0, 4'd0, 1, 0, 3'd1, 9'h047, "R7 nested 0x47 blocks 0x45");
        apply(16'h0028, '0, 4'd0, 1, 0, 3'd1, 9'h045, "R8 equal type not blocked");
        apply(16'h0008, '0, 4'd0, 1, 0, 0, 0, "R6 reload level 3");
        apply(16'h0028, '0, 4'd0, 1, 0, 3'd0, 9'h047, "R8 trap level 0 not blocked");
        apply(16'h0008, '0, 4'd0, 1, 0, 0, 0, "R6 reload level 3 b");
        apply(16'h0028, '0, 4'd0, 1, 0, 3'd2, 9'h147, "R8 outside group not blocked");
        apply(16'h0028, '0, 4'd0, 0, 0, 0, 0, "R9 disable clears");
        apply(16'h0028, '0, 4'd0, 0, 0, 0, 0, "R9 disabled stays idle");
        apply(16'h8000, '0, 4'd14, 1, 0, 0, 0, "R6 level 15 over cur 14");
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule